// File: doc/BRIEF.md
# Fracturable LUT pair cell

This cell models two adjacent lookup-table slots of a programmable logic slice. A single 64-entry truth table can act as one 6-input function, or it can split into two narrower functions. The two narrow functions either share their five low input pins or, if each has three inputs or fewer, take separate groups of pins. A slice would hold eight of these cells. Cell k covers slots 2k (the even slot) and 2k+1 (the odd slot).

The truth table and the operating mode are loaded together through a write-enabled register port on the rising clock edge. After a load, both outputs are purely combinational functions of the six input pins. The table inputs and the mode inputs have no effect until the next load.

Top module: `lut_pair_cell`

## Requirements
- R1: While rst_ni is low, and after it is released with no load, the stored table is all zeros and the mode is wide, so even_o and odd_o are both 0.
- R2: On a rising clk_i edge with cfg_we_i high, cfg_table_i and cfg_mode_i are captured. The outputs reflect the new contents from that edge onward.
- R3: Wide mode (cfg_mode_i = 2'b00): odd_o = T[pin_i[5:0]] and even_o is 0, because the even slot is unused.
- R4: Shared mode (2'b01): even_o = T[{0,pin_i[4:0]}] and odd_o = T[{1,pin_i[4:0]}]. pin_i[5] has no effect on either output.
- R5: Split mode (2'b10): even_o = T[pin_i[2:0]] (entries 0 to 7) and odd_o = T[32 + pin_i[5:3]] (entries 32 to 39). pin_i[5:3] has no effect on even_o, and pin_i[2:0] has no effect on odd_o.
- R6: Off mode (2'b11): both outputs are 0 for every pin pattern.
- R7: While cfg_we_i stays low and the pins stay still, the outputs hold their values. Changes on cfg_table_i or cfg_mode_i with cfg_we_i low do not alter the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Configuration load clock |
| rst_ni | input | 1 | Active-low asynchronous reset of the stored configuration |
| cfg_we_i | input | 1 | Load strobe for table and mode |
| cfg_table_i | input | 64 | Truth table to load; bit n is entry n |
| cfg_mode_i | input | 2 | Mode to load: 00 wide, 01 shared, 10 split, 11 off |
| pin_i | input | 6 | Function input pins |
| even_o | output | 1 | Even-slot function output |
| odd_o | output | 1 | Odd-slot function output |

## Verification
The bench checks that the single wide output appears on the odd slot only. A design that routed it to the even slot, or that let the idle even slot follow the table, fails those vectors. It also flips the pin groups that each narrow mode must ignore. A cell that decoded pin 5 in shared mode, or that mixed the two three-pin groups in split mode, reads the wrong half or the wrong eight entries of the table. Loads are timed against the clock edge, and the table and mode inputs are driven with the strobe low. This catches a transparent or level-sensitive load and a table that ignores the write enable.

// File: rtl/lut_pair_pkg.sv
package lut_pair_pkg;
  typedef enum logic [1:0] {
    MODE_WIDE   = 2'b00,
    MODE_SHARED = 2'b01,
    MODE_SPLIT  = 2'b10,
    MODE_OFF    = 2'b11
  } lut_mode_e;

  localparam int unsigned NUM_SLOTS = 2;
endpackage

// File: rtl/lut_pair_cfg_reg.sv
module lut_pair_cfg_reg
  import lut_pair_pkg::*;
#(
  parameter int unsigned TABLE_W = 64
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               we_i,
  input  logic [TABLE_W-1:0] table_i,
  input  logic [1:0]         mode_i,
  output logic [TABLE_W-1:0] table_o,
  output lut_mode_e          mode_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      table_o <= '0;
      mode_o  <= MODE_WIDE;
    end else if (we_i) begin
      table_o <= table_i;
      mode_o  <= lut_mode_e'(mode_i);
    end
  end
endmodule

// File: rtl/lut_pair_addr.sv
module lut_pair_addr
  import lut_pair_pkg::*;
#(
  parameter int unsigned NUM_IN = 6
) (
  input  lut_mode_e         mode_i,
  input  logic [NUM_IN-1:0] pin_i,
  output logic [NUM_IN-1:0] even_addr_o,
  output logic [NUM_IN-1:0] odd_addr_o,
  output logic              even_en_o,
  output logic              odd_en_o
);
  localparam int unsigned LO_W = NUM_IN / 2;
  localparam int unsigned HI_W = NUM_IN - LO_W;

  always_comb begin
    even_addr_o = '0;
    odd_addr_o  = '0;
    even_en_o   = 1'b0;
    odd_en_o    = 1'b0;
    unique case (mode_i)
      MODE_WIDE: begin
        odd_addr_o = pin_i;
        odd_en_o   = 1'b1;
      end
      MODE_SHARED: begin
        // top pin replaced by slot select
        even_addr_o = {1'b0, pin_i[NUM_IN-2:0]};
        odd_addr_o  = {1'b1, pin_i[NUM_IN-2:0]};
        even_en_o   = 1'b1;
        odd_en_o    = 1'b1;
      end
      MODE_SPLIT: begin
        even_addr_o[LO_W-1:0] = pin_i[LO_W-1:0];
        odd_addr_o[HI_W-1:0]  = pin_i[NUM_IN-1:LO_W];
        odd_addr_o[NUM_IN-1]  = 1'b1;
        even_en_o   = 1'b1;
        odd_en_o    = 1'b1;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/lut_pair_sel.sv
module lut_pair_sel #(
  parameter int unsigned NUM_IN  = 6,
  localparam int unsigned TABLE_W = 1 << NUM_IN
) (
  input  logic [TABLE_W-1:0] table_i,
  input  logic [NUM_IN-1:0]  addr_i,
  input  logic               en_i,
  output logic               bit_o
);
  assign bit_o = en_i & table_i[addr_i];
endmodule

// File: rtl/lut_pair_cell.sv
module lut_pair_cell
  import lut_pair_pkg::*;
#(
  parameter int unsigned NUM_IN  = 6,
  localparam int unsigned TABLE_W = 1 << NUM_IN
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cfg_we_i,
  input  logic [TABLE_W-1:0] cfg_table_i,
  input  logic [1:0]         cfg_mode_i,
  input  logic [NUM_IN-1:0]  pin_i,
  output logic               even_o,
  output logic               odd_o
);
  logic [TABLE_W-1:0] table_q;
  lut_mode_e          mode_q;
  logic [NUM_IN-1:0]  even_addr, odd_addr;
  logic               even_en, odd_en;
  logic [NUM_IN-1:0]  slot_addr [NUM_SLOTS];
  logic               slot_en   [NUM_SLOTS];
  logic               slot_out  [NUM_SLOTS];

  lut_pair_cfg_reg #(.TABLE_W(TABLE_W)) u_cfg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (cfg_we_i),
    .table_i (cfg_table_i),
    .mode_i  (cfg_mode_i),
    .table_o (table_q),
    .mode_o  (mode_q)
  );

  lut_pair_addr #(.NUM_IN(NUM_IN)) u_addr (
    .mode_i      (mode_q),
    .pin_i       (pin_i),
    .even_addr_o (even_addr),
    .odd_addr_o  (odd_addr),
    .even_en_o   (even_en),
    .odd_en_o    (odd_en)
  );

  assign slot_addr[0] = even_addr;
  assign slot_addr[1] = odd_addr;
  assign slot_en[0]   = even_en;
  assign slot_en[1]   = odd_en;

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    lut_pair_sel #(.NUM_IN(NUM_IN)) u_sel (
      .table_i (table_q),
      .addr_i  (slot_addr[s]),
      .en_i    (slot_en[s]),
      .bit_o   (slot_out[s])
    );
  end

  assign even_o = slot_out[0];
  assign odd_o  = slot_out[1];
endmodule

// File: rtl/lut_pair_cell_chk.sv
module lut_pair_cell_chk
  import lut_pair_pkg::*;
#(
  parameter int unsigned NUM_IN = 6
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cfg_we_i,
  input logic [NUM_IN-1:0] pin_i,
  input lut_mode_e         mode_q,
  input logic [NUM_IN-1:0] even_addr,
  input logic [NUM_IN-1:0] odd_addr,
  input logic              even_o,
  input logic              odd_o
);
  localparam int unsigned LO_W = NUM_IN / 2;
  localparam int unsigned HI_W = NUM_IN - LO_W;

  p_reset_idle_r1: assert property (@(posedge clk_i)
    !rst_ni |-> (!even_o && !odd_o));

  p_wide_even_idle_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == MODE_WIDE) |-> (!even_o && odd_addr == pin_i));

  p_shared_halves_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == MODE_SHARED) |->
      (!even_addr[NUM_IN-1] && odd_addr[NUM_IN-1] &&
       even_addr[NUM_IN-2:0] == pin_i[NUM_IN-2:0] &&
       odd_addr[NUM_IN-2:0]  == pin_i[NUM_IN-2:0]));

  p_split_groups_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == MODE_SPLIT) |->
      (even_addr[LO_W-1:0] == pin_i[LO_W-1:0] &&
       even_addr[NUM_IN-1:LO_W] == '0 &&
       odd_addr[HI_W-1:0] == pin_i[NUM_IN-1:LO_W] &&
       odd_addr[NUM_IN-1]));

  p_off_quiet_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == MODE_OFF) |-> (!even_o && !odd_o));

  p_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$past(cfg_we_i) && $stable(pin_i)) |-> ($stable(even_o) && $stable(odd_o)));
endmodule

bind lut_pair_cell lut_pair_cell_chk #(.NUM_IN(NUM_IN)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .cfg_we_i  (cfg_we_i),
  .pin_i     (pin_i),
  .mode_q    (mode_q),
  .even_addr (even_addr),
  .odd_addr  (odd_addr),
  .even_o    (even_o),
  .odd_o     (odd_o)
);

// File: tb/lut_pair_cell_test.sv
module lut_pair_cell_test;
  localparam logic [63:0] TBL_A = 64'hFFFF_FFFF_0000_0000; // entry n = n[5]
  localparam logic [63:0] TBL_B = 64'hAAAA_AAAA_AAAA_AAAA; // entry n = n[0]
  localparam int NVEC = 13;
  // {table sel, mode, pin, exp even, exp odd}
  localparam logic [10:0] VEC [NVEC] = '{
    {1'b0, 2'b00, 6'b100000, 1'b0, 1'b1},
    {1'b0, 2'b00, 6'b011111, 1'b0, 1'b0},
    {1'b0, 2'b01, 6'b000000, 1'b0, 1'b1},
    {1'b0, 2'b01, 6'b111111, 1'b0, 1'b1},
    {1'b0, 2'b10, 6'b111111, 1'b0, 1'b1},
    {1'b0, 2'b11, 6'b100000, 1'b0, 1'b0},
    {1'b1, 2'b00, 6'b000001, 1'b0, 1'b1},
    {1'b1, 2'b00, 6'b111110, 1'b0, 1'b0},
    {1'b1, 2'b01, 6'b100001, 1'b1, 1'b1},
    {1'b1, 2'b01, 6'b000010, 1'b0, 1'b0},
    {1'b1, 2'b10, 6'b001000, 1'b0, 1'b1},
    {1'b1, 2'b10, 6'b000001, 1'b1, 1'b0},
    {1'b1, 2'b11, 6'b111111, 1'b0, 1'b0}
  };

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cfg_we_i = 1'b0;
  logic [63:0] cfg_table_i = '0;
  logic [1:0]  cfg_mode_i = '0;
  logic [5:0]  pin_i = '0;
  logic        even_o, odd_o;
  int          n_chk = 0;
  int          n_bad = 0;
  bit          done = 1'b0;

  always #2 clk_i = ~clk_i;

  lut_pair_cell uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .cfg_we_i(cfg_we_i),
    .cfg_table_i(cfg_table_i), .cfg_mode_i(cfg_mode_i),
    .pin_i(pin_i), .even_o(even_o), .odd_o(odd_o)
  );

  function automatic logic [1:0] ref_out(logic [63:0] t, logic [1:0] m, logic [5:0] p);
    case (m)
      2'b00:   return {1'b0, t[p]};
      2'b01:   return {t[{1'b0, p[4:0]}], t[{1'b1, p[4:0]}]};
      2'b10:   return {t[{3'b000, p[2:0]}], t[{3'b100, p[5:3]}]};
      default: return 2'b00;
    endcase
  endfunction

  task automatic check(string req, logic [1:0] exp);
    n_chk++;
    if ({even_o, odd_o} !== exp) begin
      n_bad++;
      $display("FAIL %s: pin=%b got even/odd=%b expected %b", req, pin_i, {even_o, odd_o}, exp);
    end
  endtask

  task automatic load(logic [63:0] t, logic [1:0] m);
    @(negedge clk_i);
    cfg_table_i = t;
    cfg_mode_i  = m;
    cfg_we_i    = 1'b1;
    @(posedge clk_i);
    #1 cfg_we_i = 1'b0;
  endtask

  task automatic apply(logic [5:0] p);
    @(negedge clk_i);
    pin_i = p;
    #1;
  endtask

  initial begin
    #400000;
    n_bad++;
    $display("FAIL watchdog: run did not finish, got hang expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [63:0] t;
    logic [1:0]  snap;
    // R1: during reset and after release
    apply(6'b101010);
    check("R1", 2'b00);
    rst_ni = 1'b1;
    for (int p = 0; p < 64; p += 9) begin
      apply(6'(p));
      check("R1", 2'b00);
    end

    // table of vectors: R3 R4 R5 R6
    for (int i = 0; i < NVEC; i++) begin
      load(VEC[i][10] ? TBL_B : TBL_A, VEC[i][9:8]);
      apply(VEC[i][7:2]);
      case (VEC[i][9:8])
        2'b00:   check("R3", VEC[i][1:0]);
        2'b01:   check("R4", VEC[i][1:0]);
        2'b10:   check("R5", VEC[i][1:0]);
        default: check("R6", VEC[i][1:0]);
      endcase
    end

    // exhaustive sweep, random tables, every mode
    for (int r = 0; r < 3; r++) begin
      for (int m = 0; m < 4; m++) begin
        t = {$urandom, $urandom};
        load(t, 2'(m));
        for (int p = 0; p < 64; p++) begin
          apply(6'(p));
          case (m)
            0:       check("R3", ref_out(t, 2'(m), 6'(p)));
            1:       check("R4", ref_out(t, 2'(m), 6'(p)));
            2:       check("R5", ref_out(t, 2'(m), 6'(p)));
            default: check("R6", ref_out(t, 2'(m), 6'(p)));
          endcase
        end
      end
    end

    // R2: new table visible only after the loading edge
    load(TBL_A, 2'b00);
    apply(6'b100000);
    @(negedge clk_i);
    cfg_table_i = ~TBL_A;
    cfg_we_i = 1'b1;
    #1 check("R2", 2'b01);
    @(posedge clk_i);
    #1 cfg_we_i = 1'b0;
    check("R2", 2'b00);

    // R7: table and mode inputs ignored while strobe low
    t = {$urandom, $urandom};
    load(t, 2'b01);
    for (int p = 0; p < 64; p += 5) begin
      apply(6'(p));
      snap = ref_out(t, 2'b01, 6'(p));
      @(negedge clk_i);
      cfg_table_i = ~t;
      cfg_mode_i  = 2'b11;
      repeat (2) @(posedge clk_i);
      #1 check("R7", snap);
    end

    // R1 again: reset clears a loaded configuration
    load(64'hFFFF_FFFF_FFFF_FFFF, 2'b01);
    apply(6'b000011);
    check("R4", 2'b11);
    rst_ni = 1'b0;
    #1 check("R1", 2'b00);
    @(negedge clk_i);
    rst_ni = 1'b1;
    apply(6'b111111);
    check("R1", 2'b00);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule